// File: doc/BRIEF.md
# Crystal Frequency Window Monitor

This block watches an external crystal clock from inside the system clock domain. The crystal arrives as a one-cycle tick strobe that has already been synchronised into the system clock. The block counts those ticks over a fixed window of system clock cycles. At the end of each window it checks the count against a programmable lower bound and upper bound. A count outside that band marks the crystal frequency as abnormal.

A second, independent path detects a crystal that has stopped. If no tick arrives for a programmed number of consecutive system cycles, that path raises its own flag. Each path has a detector enable, an interrupt enable and a sticky status flag that software clears by writing 1 to it. A small register bus sets up both paths and reads them back. The two flags are also driven straight out as pins, along with a single combined interrupt.

Top module: `xtal_win_monitor`

## Requirements
- R1: Register map on `bus_addr`. Address 0 is control: bit 0 enables the frequency detector, bit 1 enables its interrupt, bit 2 enables the stop detector and bit 3 enables its interrupt. Address 1 holds the 10-bit upper bound. Address 2 holds the 10-bit lower bound. Address 3 is status: bit 0 is the frequency fault and bit 1 is the stop fault. A read returns the stored value with unused bits at 0. Reset clears every register, and a write of 0x3FF to a bound reads back 0x3FF.
- R2: While the frequency detector is enabled, ticks are counted over windows of WIN_CYCLES system cycles. A new window starts in the cycle after the enable takes effect. The fault flag is set on the clock edge that closes the window.
- R3: The frequency fault is raised when the window count is strictly above the upper bound or strictly below the lower bound. A count equal to either bound is not a fault.
- R4: The window count saturates at 1023 and never wraps.
- R5: With the stop detector enabled, STOP_CYCLES consecutive system cycles without a tick set the stop fault on the edge of the last such cycle. Any tick restarts the count, and the count also restarts after each detection.
- R6: Both flags are sticky. Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: While a detector enable is 0, its counters are held at zero and its flag cannot be set. A flag that was already set keeps its value.
- R8: `irq` is high when the frequency fault is set with its interrupt enabled, or when the stop fault is set with its interrupt enabled. The interrupt enables do not affect the flags.
- R9: `freq_fault` and `stop_fault` always show the two status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which is also the reference clock for the windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Crystal edge strobe, already synchronised to clk |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for both write and read |
| bus_wdata | input | 10 | Register write data |
| bus_rdata | output | 10 | Read data for `bus_addr` (combinational) |
| freq_fault | output | 1 | Frequency-out-of-band flag |
| stop_fault | output | 1 | Stopped-crystal flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench targets the edges of the comparison. Counts exactly equal to a bound, and counts one above and one below, are each placed inside a single window. An off-by-one comparator would flag the equal case or miss the neighbours. A window carrying more than 1023 ticks is checked against a band near the top of the range. A counter that wraps would land far below the lower bound and raise a false fault. The bench also times the flag to the exact edge that closes the window and to the exact cycle the stop detector fires. It then issues a clear on every cycle while the crystal is stopped, which exposes a design that lets the clear beat a coincident set. Finally, it checks that a disabled detector neither raises nor drops a flag.

// File: rtl/xwm_pkg.sv
package xwm_pkg;

   // register addresses
   localparam int unsigned XWM_A_CTRL  = 0;
   localparam int unsigned XWM_A_UPPER = 1;
   localparam int unsigned XWM_A_LOWER = 2;
   localparam int unsigned XWM_A_STAT  = 3;

   // status bit positions
   localparam int unsigned XWM_SB_FREQ = 0;
   localparam int unsigned XWM_SB_STOP = 1;

   // control word, freq_en at bit 0 up to stop_ie at bit 3
   typedef struct packed {
      logic stop_ie;
      logic stop_en;
      logic freq_ie;
      logic freq_en;
   } xwm_ctrl_t;

   localparam int unsigned XWM_CTRL_W = $bits(xwm_ctrl_t);

endpackage

// File: rtl/xwm_regs.sv
module xwm_regs
   import xwm_pkg::*;
#(
   parameter int unsigned BOUND_W = 10,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [BOUND_W-1:0] wdata,
   output logic [BOUND_W-1:0] rdata,
   output xwm_ctrl_t          ctrl,
   output logic [BOUND_W-1:0] upper,
   output logic [BOUND_W-1:0] lower,
   input  logic               freq_set,
   input  logic               stop_set,
   output logic               freq_flag,
   output logic               stop_flag
);

   generate
      if (BOUND_W < XWM_CTRL_W) begin : g_bad_width
         $error("xwm_regs: BOUND_W too narrow for the control word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("xwm_regs: ADDR_W must cover four registers");
      end
   endgenerate

   logic sel_ctrl, sel_upper, sel_lower, sel_stat;
   logic clr_freq, clr_stop;

   assign sel_ctrl  = (addr == ADDR_W'(XWM_A_CTRL));
   assign sel_upper = (addr == ADDR_W'(XWM_A_UPPER));
   assign sel_lower = (addr == ADDR_W'(XWM_A_LOWER));
   assign sel_stat  = (addr == ADDR_W'(XWM_A_STAT));

   assign clr_freq = wr_en && sel_stat && wdata[XWM_SB_FREQ];
   assign clr_stop = wr_en && sel_stat && wdata[XWM_SB_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         upper <= '0;
         lower <= '0;
      end else if (wr_en) begin
         if (sel_ctrl)  ctrl  <= xwm_ctrl_t'(wdata[XWM_CTRL_W-1:0]);
         if (sel_upper) upper <= wdata;
         if (sel_lower) lower <= wdata;
      end
   end

   // sticky flags: a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_flag <= 1'b0;
         stop_flag <= 1'b0;
      end else begin
         freq_flag <= freq_set | (freq_flag & ~clr_freq);
         stop_flag <= stop_set | (stop_flag & ~clr_stop);
      end
   end

   always_comb begin
      rdata = '0;
      if (sel_ctrl) begin
         rdata[XWM_CTRL_W-1:0] = ctrl;
      end else if (sel_upper) begin
         rdata = upper;
      end else if (sel_lower) begin
         rdata = lower;
      end else if (sel_stat) begin
         rdata[XWM_SB_FREQ] = freq_flag;
         rdata[XWM_SB_STOP] = stop_flag;
      end
   end

   AST_FREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_flag && !clr_freq) |=> freq_flag); // R6
   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_flag && !clr_stop) |=> stop_flag); // R6
   AST_FREQ_OFF_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
      (!freq_flag && !ctrl.freq_en) |=> !freq_flag); // R7
   AST_STOP_OFF_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_flag && !ctrl.stop_en) |=> !stop_flag); // R7

endmodule

// File: rtl/xwm_freq_meter.sv
module xwm_freq_meter #(
   parameter int unsigned BOUND_W    = 10,
   parameter int unsigned WIN_CYCLES = 1200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic [BOUND_W-1:0] upper,
   input  logic [BOUND_W-1:0] lower,
   output logic               fault_set
);

   localparam int unsigned WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [BOUND_W-1:0] CNT_MAX = '1;
   localparam logic [WIN_W-1:0]   WIN_LAST = WIN_W'(WIN_CYCLES - 1);

   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("xwm_freq_meter: WIN_CYCLES must be at least 2");
      end
   endgenerate

   logic [WIN_W-1:0]   win_q;
   logic [BOUND_W-1:0] cnt_q;
   logic [BOUND_W-1:0] cnt_nx;
   logic               win_end;

   assign win_end = (win_q == WIN_LAST);
   assign cnt_nx  = (cnt_q == CNT_MAX) ? cnt_q
                                       : cnt_q + {{(BOUND_W-1){1'b0}}, tick};

   assign fault_set = en && win_end && ((cnt_nx > upper) || (cnt_nx < lower));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         cnt_q <= '0;
      end else if (!en || win_end) begin
         win_q <= '0;
         cnt_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         cnt_q <= cnt_nx;
      end
   end

   AST_METER_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (win_q == '0 && cnt_q == '0)); // R7
   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !win_end && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4

endmodule

// File: rtl/xwm_stop_det.sv
module xwm_stop_det #(
   parameter int unsigned STOP_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   output logic stop_set
);

   localparam int unsigned IDLE_W = (STOP_CYCLES > 2) ? $clog2(STOP_CYCLES) : 1;
   localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(STOP_CYCLES - 1);

   generate
      if (STOP_CYCLES < 2) begin : g_bad_stop
         $error("xwm_stop_det: STOP_CYCLES must be at least 2");
      end
   endgenerate

   logic [IDLE_W-1:0] idle_q;

   assign stop_set = en && !tick && (idle_q == IDLE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (!en || tick || stop_set) begin
         idle_q <= '0;
      end else begin
         idle_q <= idle_q + 1'b1;
      end
   end

   AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> (idle_q == '0)); // R5
   AST_IDLE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (idle_q == '0)); // R7

endmodule

// File: rtl/xtal_win_monitor.sv
module xtal_win_monitor
   import xwm_pkg::*;
#(
   parameter int unsigned BOUND_W     = 10,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned WIN_CYCLES  = 1200,
   parameter int unsigned STOP_CYCLES = 40,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xtal_tick,
   input  logic               bus_wr_en,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BOUND_W-1:0] bus_wdata,
   output logic [BOUND_W-1:0] bus_rdata,
   output logic               freq_fault,
   output logic               stop_fault,
   output logic               irq
);

   xwm_ctrl_t          ctrl;
   logic [BOUND_W-1:0] upper, lower;
   logic               freq_set, stop_set;
   logic               freq_flag, stop_flag;
   logic               irq_raw;

   xwm_regs #(.BOUND_W(BOUND_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr_en),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .ctrl     (ctrl),
      .upper    (upper),
      .lower    (lower),
      .freq_set (freq_set),
      .stop_set (stop_set),
      .freq_flag(freq_flag),
      .stop_flag(stop_flag)
   );

   xwm_freq_meter #(.BOUND_W(BOUND_W), .WIN_CYCLES(WIN_CYCLES)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl.freq_en),
      .tick     (xtal_tick),
      .upper    (upper),
      .lower    (lower),
      .fault_set(freq_set)
   );

   xwm_stop_det #(.STOP_CYCLES(STOP_CYCLES)) u_stop (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.stop_en),
      .tick    (xtal_tick),
      .stop_set(stop_set)
   );

   assign freq_fault = freq_flag;
   assign stop_fault = stop_flag;
   assign irq_raw    = (freq_flag & ctrl.freq_ie) | (stop_flag & ctrl.stop_ie);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;

         AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (freq_fault || stop_fault)); // R8
         AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl.freq_ie && !ctrl.stop_ie) |-> !irq); // R8
      end
   endgenerate

endmodule

// File: tb/tb_xtal_win_monitor.sv
module tb_xtal_win_monitor;

   localparam int CLK_PERIOD = 10;
   localparam int WIN  = 1200;
   localparam int STOP = 40;
   localparam int MAXC = 1023;
   localparam logic [9:0] C_FEN = 10'h1, C_FIE = 10'h2, C_SEN = 10'h4, C_SIE = 10'h8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xtal_tick = 1'b0;
   logic       bus_wr_en = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [9:0] bus_wdata = 10'd0;
   logic [9:0] bus_rdata;
   logic       freq_fault, stop_fault, irq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xtal_win_monitor #(
      .BOUND_W(10), .ADDR_W(2), .WIN_CYCLES(WIN), .STOP_CYCLES(STOP), .IRQ_REG(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick),
      .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .freq_fault(freq_fault), .stop_fault(stop_fault), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_fen, m_fie, m_sen, m_sie, m_ff, m_sf;
   int m_up, m_lo, m_win, m_cnt, m_idle;
   int c_tmp;
   bit f_set, s_set, c_f, c_s;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fen = 0; m_fie = 0; m_sen = 0; m_sie = 0; m_ff = 0; m_sf = 0;
         m_up = 0; m_lo = 0; m_win = 0; m_cnt = 0; m_idle = 0;
      end else begin
         f_set = 0;
         if (m_fen && m_win == WIN-1) begin
            c_tmp = (m_cnt >= MAXC) ? MAXC : m_cnt + int'(xtal_tick);
            f_set = (c_tmp > m_up) || (c_tmp < m_lo);
         end
         if (!m_fen || m_win == WIN-1) begin
            m_win = 0; m_cnt = 0;
         end else begin
            m_win++;
            if (xtal_tick && m_cnt < MAXC) m_cnt++;
         end
         s_set = m_sen && !xtal_tick && (m_idle == STOP-1);
         if (!m_sen || xtal_tick || s_set) m_idle = 0; else m_idle++;
         c_f = bus_wr_en && bus_addr == 2'd3 && bus_wdata[0];
         c_s = bus_wr_en && bus_addr == 2'd3 && bus_wdata[1];
         m_ff = f_set || (m_ff && !c_f);
         m_sf = s_set || (m_sf && !c_s);
         if (bus_wr_en) begin
            case (bus_addr)
               2'd0: begin
                  m_fen = bus_wdata[0]; m_fie = bus_wdata[1];
                  m_sen = bus_wdata[2]; m_sie = bus_wdata[3];
               end
               2'd1: m_up = int'(bus_wdata);
               2'd2: m_lo = int'(bus_wdata);
               default: ;
            endcase
         end
      end
   end

   function automatic logic [9:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return {6'd0, m_sie, m_sen, m_fie, m_fen};
         2'd1: return 10'(m_up);
         2'd2: return 10'(m_lo);
         default: return {8'd0, m_sf, m_ff};
      endcase
   endfunction

   // compare against the model on every clock, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         chk("R9 freq_fault pin", 32'(freq_fault), 32'(m_ff));
         chk("R9 stop_fault pin", 32'(stop_fault), 32'(m_sf));
         chk("R8 irq", 32'(irq), 32'((m_ff && m_fie) || (m_sf && m_sie)));
         chk("R1 read data", 32'(bus_rdata), 32'(exp_read(bus_addr)));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [9:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_wdata = 10'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic burst(input int n);
      xtal_tick = 1'b1;
      repeat (n) @(negedge clk);
      xtal_tick = 1'b0;
   endtask

   // one window carrying exactly n ticks (n <= WIN-2)
   task automatic freq_trial(input int n, input bit expf, input logic [9:0] ctl, input string tag);
      wr(2'd0, 10'd0);
      wr(2'd3, 10'h1);
      wr(2'd0, ctl);
      idle(1);
      burst(n);
      idle(WIN - n - 2);
      chk({tag, " R2 flag clear before window end"}, 32'(freq_fault), 32'd0);
      idle(1);
      chk({tag, " R2 flag at window end"}, 32'(freq_fault), 32'(expf));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      bit seen;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values and bound width
      for (int a = 0; a < 4; a++) begin
         bus_addr = 2'(a);
         #1;
         chk("R1 reset value", 32'(bus_rdata), 32'd0);
      end
      chk("R1 reset pins", 32'({freq_fault, stop_fault, irq}), 32'd0);
      wr(2'd1, 10'h3FF);
      bus_addr = 2'd1; #1;
      chk("R1 upper readback", 32'(bus_rdata), 32'h3FF);
      wr(2'd2, 10'h3FF);
      bus_addr = 2'd2; #1;
      chk("R1 lower readback", 32'(bus_rdata), 32'h3FF);

      // R3: bounds and equality
      wr(2'd1, 10'd40);
      wr(2'd2, 10'd40);
      freq_trial(40, 1'b0, C_FEN | C_FIE, "R3 equal");
      freq_trial(41, 1'b1, C_FEN | C_FIE, "R3 above");
      chk("R8 irq with enable", 32'(irq), 32'd1);
      freq_trial(39, 1'b1, C_FEN, "R3 below");
      chk("R8 irq masked, flag still set", 32'({freq_fault, irq}), 32'b10);

      // R6 / R7: disabled keeps the flag, write 0 no effect, write 1 clears
      wr(2'd0, 10'd0);
      idle(100);
      chk("R7 flag kept while disabled", 32'(freq_fault), 32'd1);
      wr(2'd3, 10'd0);
      chk("R6 write 0 keeps flag", 32'(freq_fault), 32'd1);
      wr(2'd3, 10'h1);
      chk("R6 write 1 clears flag", 32'(freq_fault), 32'd0);
      idle(2*WIN + 10);
      chk("R7 disabled meter cannot set", 32'(freq_fault), 32'd0);

      // R4: saturation at 1023
      wr(2'd1, 10'd1023);
      wr(2'd2, 10'd1000);
      freq_trial(WIN - 2, 1'b0, C_FEN, "R4 saturation");
      wr(2'd0, 10'd0);
      wr(2'd3, 10'h3);

      // R5: stop detection timing
      wr(2'd0, C_SEN | C_SIE);
      idle(STOP - 1);
      chk("R5 no stop one cycle early", 32'(stop_fault), 32'd0);
      idle(1);
      chk("R5 stop set at limit", 32'(stop_fault), 32'd1);
      chk("R8 stop irq", 32'(irq), 32'd1);

      // R5: ticks restart the count
      wr(2'd0, 10'd0);
      wr(2'd3, 10'h3);
      wr(2'd0, C_SEN | C_SIE);
      for (int i = 0; i < 10; i++) begin
         idle(STOP - 4);
         burst(1);
      end
      chk("R5 periodic ticks keep stop clear", 32'(stop_fault), 32'd0);

      // R6: set beats a coincident clear
      seen = 1'b0;
      bus_wr_en = 1'b1; bus_addr = 2'd3; bus_wdata = 10'h2;
      for (int i = 0; i < 3*STOP; i++) begin
         @(negedge clk);
         if (stop_fault) seen = 1'b1;
      end
      bus_wr_en = 1'b0; bus_wdata = 10'd0;
      chk("R6 set wins over clear", 32'(seen), 32'd1);

      // R7: disabled stop detector
      wr(2'd0, 10'd0);
      wr(2'd3, 10'h3);
      idle(3*STOP);
      chk("R7 disabled stop detector cannot set", 32'(stop_fault), 32'd0);

      idle(2);
      summary();
      $finish;
   end

endmodule